// File: doc/BRIEF.md
# PCIe Receive Payload Realigner

This block sits behind the receive side of a PCI Express transaction layer. It takes whole transaction layer packets from a 64-bit valid/ready stream with start-of-packet and end-of-packet flags. It removes the 3- or 4-dword header and returns only the payload, packed so that payload dword 0 always starts in the low half of the first output beat. Each output beat carries one enable bit per byte. The enables come from the first-dword and last-dword byte-enable fields of the header and from the dword length.

In the input stream, the position of the first payload dword depends on the header size and on address bit 2. Depending on those two, the payload may start in the high half of a beat, or a filler dword may sit between the header and the payload. When the payload starts in a high half, the realigner holds one dword and pairs it with the next one. If that leaves a dword over after the last input beat, the realigner emits one extra output beat on its own.

The decoded header fields are driven on sideband ports. They are valid on the beat that carries the output start-of-packet flag. A packet with no payload produces a single beat with every enable cleared.

Top module: `rx_payload_align`

## Requirements
- R1: Within each input beat, bits [31:0] hold the earlier dword and bits [63:32] the later one. The start-of-packet beat carries header dwords 0 and 1. Header decode:
  - Length is in dword 0 bits [9:0], where 0 means 1024.
  - Dword 0 bit 29 flags a 4-dword header.
  - Dword 0 bit 30 flags a payload.
  - The first-dword enables are in dword 1 bits [3:0] and the last-dword enables in dword 1 bits [7:4].
  - These values appear on hdrLen, hdr4Dw, hdrHasData, hdrFirstBe and hdrLastBe on the output start-of-packet beat.
- R2: Payload dwords leave in order, with none lost or repeated. Dword 2k appears in outData[31:0] and dword 2k+1 in outData[63:32] of output beat k of the packet.
- R3: Address bit 2 is header dword 2 bit 2 for a 3-dword header and header dword 3 bit 2 for a 4-dword header. The first payload dword is found at:
  - 3-dword header, bit set: high half of input beat 1.
  - 3-dword header, bit clear: low half of beat 2, after a filler dword.
  - 4-dword header, bit clear: low half of beat 2.
  - 4-dword header, bit set: high half of beat 2, after a filler dword.
  All four cases give the same output as R2.
- R4: outBe bit i qualifies outData[8i+7:8i]. Enables per payload dword:
  - Payload dword 0 takes the first-dword field.
  - The last dword takes the last-dword field when the length exceeds 1.
  - Every other payload dword takes 4'hF.
  - A single-dword payload uses only the first-dword field.
- R5: With an odd dword count, the final output beat has outBe[7:4]=0 and outData[63:32]=0. Every output beat that is not the last one has outBe[7:4]=4'hF.
- R6: outSop is high on the first output beat of each packet and outEop on its last. The next beat after a beat without outEop does not carry outSop.
- R7: A packet whose payload flag is clear yields exactly one output beat with outSop=1, outEop=1, outBe=0, outData=0 and hdrHasData=0.
- R8: inReady is low whenever outReady is low. While outValid is high and outReady low, outValid, outData and outBe stay unchanged on the next cycle. Under random stalls on both sides, no data is lost or repeated.
- R9: During reset and after it, outValid stays low until a packet is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 64 | Input packet beat |
| inValid | input | 1 | Input beat valid |
| inSop | input | 1 | Input beat is the first of a packet |
| inEop | input | 1 | Input beat is the last of a packet |
| inReady | output | 1 | Input beat accepted when high with inValid |
| outData | output | 64 | Aligned payload beat |
| outBe | output | 8 | Byte enables for outData |
| outValid | output | 1 | Output beat valid |
| outSop | output | 1 | First output beat of a packet |
| outEop | output | 1 | Last output beat of a packet |
| outReady | input | 1 | Downstream accepts the output beat |
| hdrLen | output | 11 | Decoded length in dwords (1..1024) |
| hdr4Dw | output | 1 | Packet used a 4-dword header |
| hdrHasData | output | 1 | Packet carries a payload |
| hdrFirstBe | output | 4 | First-dword byte-enable field |
| hdrLastBe | output | 4 | Last-dword byte-enable field |

## Verification
A wrong hold-register state shows up at once at the ports. If the held dword is lost or stale, the very next output beat of the packet carries the wrong low dword. If the flush beat is missed, the packet gets no outEop, and the following packet's header then shows up as payload.

A wrong remaining-count register shifts the enables. That puts the last-dword field on the wrong beat, or clears the upper enables one beat early, within one or two output beats.

A wrong alignment decision for any of the four header and address cases moves every payload dword by one half-beat, so it is visible on the first output beat.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  localparam int DWORD_BITS   = 32;
  localparam int BEAT_BITS    = 2 * DWORD_BITS;
  localparam int LEN_BITS     = 10;
  localparam int CNT_BITS     = LEN_BITS + 1;
  localparam int DW_BE_BITS   = DWORD_BITS / 8;
  localparam int BEAT_BE_BITS = 2 * DW_BE_BITS;

  typedef enum logic [1:0] {
    ST_HDR0,
    ST_HDR1,
    ST_BODY,
    ST_FLUSH
  } rxaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                emit;
    logic                loV;
    logic                useHold;
    logic                storeEn;
    logic                storeHi;
    logic                hdrOnly;
    logic                startPkt;
    logic [CNT_BITS-1:0] startLen;
  } rxaStrobe_t;
endpackage

// File: rtl/rxa_ctrl.sv
module rxa_ctrl
  import rxa_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  inSop,
  input  logic                  inEop,
  input  logic                  outReady,
  input  logic [LEN_BITS-1:0]   lenField,
  input  logic                  fmt4Bit,
  input  logic                  dataBit,
  input  logic [DW_BE_BITS-1:0] firstBeField,
  input  logic [DW_BE_BITS-1:0] lastBeField,
  input  logic                  addr3dwBit,
  input  logic                  addr4dwBit,
  output logic                  inReady,
  output logic                  outValid,
  output rxaStrobe_t            st,
  output logic [CNT_BITS-1:0]   hdrLen,
  output logic                  hdr4Dw,
  output logic                  hdrHasData,
  output logic [DW_BE_BITS-1:0] hdrFirstBe,
  output logic [DW_BE_BITS-1:0] hdrLastBe
);
  rxaState_e           state;
  logic [CNT_BITS-1:0] remIn, remAfter, decodedLen;
  logic                holdV, skipLo;
  logic                loV, hiV, finalIn, hdrOnly, wantOut, accept, storeEn, pktDone;
  logic [1:0]          nIn, cnt;

  assign decodedLen = (lenField == '0) ? {1'b1, {LEN_BITS{1'b0}}} : {1'b0, lenField};

  always_comb begin
    loV = 1'b0;
    hiV = 1'b0;
    if (state == ST_HDR1) begin
      hiV = hdrHasData && !hdr4Dw && addr3dwBit;
    end else if (state == ST_BODY) begin
      loV = !skipLo && (remIn != '0);
      hiV = skipLo ? (remIn != '0) : (remIn >= CNT_BITS'(2));
    end
  end

  assign nIn      = {1'b0, loV} + {1'b0, hiV};
  assign cnt      = {1'b0, holdV} + nIn;
  assign remAfter = remIn - CNT_BITS'(nIn);
  assign finalIn  = (nIn != 2'd0) && (remAfter == '0);
  assign hdrOnly  = (state == ST_HDR1) && !hdrHasData;
  assign wantOut  = hdrOnly || (cnt >= 2'd2) || ((cnt == 2'd1) && finalIn);

  assign inReady  = outReady && (state != ST_FLUSH);
  assign outValid = (state == ST_FLUSH) || (inValid && !inSop && wantOut);
  assign accept   = inValid && inReady;
  assign storeEn  = accept && !inSop && (state != ST_HDR0) &&
                    ((cnt == 2'd3) || ((cnt == 2'd1) && !finalIn));
  assign pktDone  = accept && !inSop && (hdrOnly || finalIn);

  always_comb begin
    st          = '0;
    st.emit     = outValid && outReady;
    st.loV      = loV;
    st.useHold  = holdV;
    st.storeEn  = storeEn;
    st.storeHi  = (cnt == 2'd3) || !loV;
    st.hdrOnly  = hdrOnly;
    st.startPkt = accept && inSop;
    st.startLen = decodedLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_HDR0;
      remIn      <= '0;
      holdV      <= 1'b0;
      skipLo     <= 1'b0;
      hdrLen     <= '0;
      hdr4Dw     <= 1'b0;
      hdrHasData <= 1'b0;
      hdrFirstBe <= '0;
      hdrLastBe  <= '0;
    end else if (state == ST_FLUSH) begin
      if (st.emit) begin
        state <= ST_HDR0;
        holdV <= 1'b0;
      end
    end else if (accept) begin
      if (inSop) begin
        hdrLen     <= decodedLen;
        hdr4Dw     <= fmt4Bit;
        hdrHasData <= dataBit;
        hdrFirstBe <= firstBeField;
        hdrLastBe  <= lastBeField;
        remIn      <= decodedLen;
        holdV      <= 1'b0;
        skipLo     <= 1'b0;
        state      <= ST_HDR1;
      end else if (state != ST_HDR0) begin
        remIn  <= remAfter;
        holdV  <= storeEn;
        skipLo <= (state == ST_HDR1) && hdrHasData && hdr4Dw && addr4dwBit;
        if (hdrOnly)      state <= ST_HDR0;
        else if (finalIn) state <= (cnt == 2'd3) ? ST_FLUSH : ST_HDR0;
        else if (inEop)   state <= ST_HDR0;
        else              state <= ST_BODY;
      end
    end
  end

  // R1: header capture starts only on a start-of-packet beat from idle
  p_hdr_on_sop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (accept && state == ST_HDR0) |-> inSop);
  // R2: the beat that completes the payload count is the end-of-packet beat
  p_eop_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> inEop);
  // R3: the extra drain beat only exists while a dword is held
  p_flush_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLUSH) |-> holdV);
endmodule

// File: rtl/rxa_datapath.sv
module rxa_datapath
  import rxa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [BEAT_BITS-1:0]    inData,
  input  rxaStrobe_t              st,
  input  logic [DW_BE_BITS-1:0]   firstBe,
  input  logic [DW_BE_BITS-1:0]   lastBe,
  output logic [BEAT_BITS-1:0]    outData,
  output logic [BEAT_BE_BITS-1:0] outBe,
  output logic                    outSop,
  output logic                    outEop
);
  logic [DWORD_BITS-1:0] holdR, inLo, inHi, dwA, dwB;
  logic [CNT_BITS-1:0]   remOut;
  logic                  firstOut, hiPresent;
  logic [DW_BE_BITS-1:0] loBe, hiBe;

  assign inLo      = inData[DWORD_BITS-1:0];
  assign inHi      = inData[BEAT_BITS-1:DWORD_BITS];
  assign hiPresent = remOut >= CNT_BITS'(2);

  assign dwA = st.useHold ? holdR : (st.loV ? inLo : inHi);
  assign dwB = st.useHold ? (st.loV ? inLo : inHi) : inHi;

  assign loBe = firstOut ? firstBe : ((remOut == CNT_BITS'(1)) ? lastBe : '1);
  assign hiBe = hiPresent ? ((remOut == CNT_BITS'(2)) ? lastBe : '1) : '0;

  assign outData = st.hdrOnly ? '0 : {(hiPresent ? dwB : '0), dwA};
  assign outBe   = st.hdrOnly ? '0 : {hiBe, loBe};
  assign outSop  = firstOut;
  assign outEop  = st.hdrOnly || (remOut <= CNT_BITS'(2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdR    <= '0;
      remOut   <= '0;
      firstOut <= 1'b0;
    end else begin
      if (st.storeEn) holdR <= st.storeHi ? inHi : inLo;
      if (st.startPkt) begin
        remOut   <= st.startLen;
        firstOut <= 1'b1;
      end else if (st.emit) begin
        remOut   <= remOut - (hiPresent ? CNT_BITS'(2) : CNT_BITS'(1));
        firstOut <= 1'b0;
      end
    end
  end

  // R5: a beat that is not the last carries a full upper dword
  p_mid_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.emit && !outEop) |-> (outBe[BEAT_BE_BITS-1:DW_BE_BITS] == '1));
  // R6: after a non-final beat, the next beat is not a packet start
  p_no_resop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.emit && !outEop) |=> !outSop);
  // R7: a header-only packet is a single start-and-end beat
  p_hdr_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.emit && st.hdrOnly) |-> (outSop && outEop));
endmodule

// File: rtl/rx_payload_align.sv
module rx_payload_align
  import rxa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [BEAT_BITS-1:0]    inData,
  input  logic                    inValid,
  input  logic                    inSop,
  input  logic                    inEop,
  output logic                    inReady,
  output logic [BEAT_BITS-1:0]    outData,
  output logic [BEAT_BE_BITS-1:0] outBe,
  output logic                    outValid,
  output logic                    outSop,
  output logic                    outEop,
  input  logic                    outReady,
  output logic [CNT_BITS-1:0]     hdrLen,
  output logic                    hdr4Dw,
  output logic                    hdrHasData,
  output logic [DW_BE_BITS-1:0]   hdrFirstBe,
  output logic [DW_BE_BITS-1:0]   hdrLastBe
);
  rxaStrobe_t st;

  rxa_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inSop        (inSop),
    .inEop        (inEop),
    .outReady     (outReady),
    .lenField     (inData[LEN_BITS-1:0]),
    .fmt4Bit      (inData[29]),
    .dataBit      (inData[30]),
    .firstBeField (inData[DWORD_BITS+DW_BE_BITS-1:DWORD_BITS]),
    .lastBeField  (inData[DWORD_BITS+2*DW_BE_BITS-1:DWORD_BITS+DW_BE_BITS]),
    .addr3dwBit   (inData[2]),
    .addr4dwBit   (inData[DWORD_BITS+2]),
    .inReady      (inReady),
    .outValid     (outValid),
    .st           (st),
    .hdrLen       (hdrLen),
    .hdr4Dw       (hdr4Dw),
    .hdrHasData   (hdrHasData),
    .hdrFirstBe   (hdrFirstBe),
    .hdrLastBe    (hdrLastBe)
  );

  rxa_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .st      (st),
    .firstBe (hdrFirstBe),
    .lastBe  (hdrLastBe),
    .outData (outData),
    .outBe   (outBe),
    .outSop  (outSop),
    .outEop  (outEop)
  );

  // R8: a stalled output beat is held unchanged
  p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outBe)));
endmodule

// File: tb/rx_payload_align_test.sv
module rx_payload_align_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] inData;
  logic        inValid, inSop, inEop, inReady;
  logic [63:0] outData;
  logic [7:0]  outBe;
  logic        outValid, outSop, outEop, outReady;
  logic [10:0] hdrLen;
  logic        hdr4Dw, hdrHasData;
  logic [3:0]  hdrFirstBe, hdrLastBe;

  always #4 clk = ~clk;  // 125 MHz

  rx_payload_align uut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inSop(inSop),
    .inEop(inEop), .inReady(inReady), .outData(outData), .outBe(outBe),
    .outValid(outValid), .outSop(outSop), .outEop(outEop), .outReady(outReady),
    .hdrLen(hdrLen), .hdr4Dw(hdr4Dw), .hdrHasData(hdrHasData),
    .hdrFirstBe(hdrFirstBe), .hdrLastBe(hdrLastBe)
  );

  typedef struct packed { logic [63:0] d; logic sop; logic eop; } beat_t;
  typedef struct packed {
    logic [63:0] d; logic [7:0] be; logic sop; logic eop;
    logic [10:0] len; logic f4; logic hd; logic [3:0] fb; logic [3:0] lb;
  } exp_t;

  beat_t beatQ[$];
  exp_t  expQ[$];
  int    vectors = 0;
  int    fails   = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] dwBe(input int k, input int n, input logic [3:0] fb, input logic [3:0] lb);
    if (k == 0) return fb;
    if (k == n - 1) return lb;
    return 4'hF;
  endfunction

  task automatic addPacket(input bit f4, input bit hd, input bit a2, input int len,
                           input logic [3:0] fb, input logic [3:0] lb);
    logic [31:0] slots[$];
    logic [31:0] pay[$];
    logic [31:0] w0, w1, w2, w3;
    exp_t e;
    w0 = $urandom; w0[9:0] = (len == 1024) ? 10'd0 : 10'(len); w0[29] = f4; w0[30] = hd;
    w1 = $urandom; w1[3:0] = fb; w1[7:4] = lb;
    w2 = $urandom; w3 = $urandom;
    if (f4) w3[2] = a2; else w2[2] = a2;
    slots.push_back(w0); slots.push_back(w1); slots.push_back(w2);
    if (f4) slots.push_back(w3);
    if (hd) begin
      if ((!f4 && !a2) || (f4 && a2)) slots.push_back($urandom);
      for (int i = 0; i < len; i++) begin
        pay.push_back($urandom);
        slots.push_back(pay[i]);
      end
    end
    if (slots.size() % 2 != 0) slots.push_back($urandom);
    for (int b = 0; b < slots.size() / 2; b++) begin
      beat_t bt;
      bt.d = {slots[2*b+1], slots[2*b]};
      bt.sop = (b == 0);
      bt.eop = (b == slots.size() / 2 - 1);
      beatQ.push_back(bt);
    end
    e.len = 11'(len); e.f4 = f4; e.hd = hd; e.fb = fb; e.lb = lb;
    if (!hd) begin
      e.d = '0; e.be = '0; e.sop = 1'b1; e.eop = 1'b1;
      expQ.push_back(e);
    end else begin
      for (int k = 0; 2 * k < len; k++) begin
        bit hasHi;
        hasHi = (2 * k + 1 < len);
        e.d   = {hasHi ? pay[2*k+1] : 32'h0, pay[2*k]};
        e.be  = {hasHi ? dwBe(2*k+1, len, fb, lb) : 4'h0, dwBe(2*k, len, fb, lb)};
        e.sop = (k == 0);
        e.eop = (2 * k + 2 >= len);
        expQ.push_back(e);
      end
    end
  endtask

  initial begin
    int  cyc;
    int  idx;
    bit  pend;
    exp_t e;
    void'($urandom(32'd4242));
    rstN = 1'b0; inValid = 1'b0; inSop = 1'b0; inEop = 1'b0; inData = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 outValid during reset", 64'(outValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 outValid idle after reset", 64'(outValid), 64'd0);

    // directed: all header/alignment combinations, short lengths
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 2; a++)
        for (int l = 1; l <= 4; l++)
          addPacket(f[0], 1'b1, a[0], l, 4'($urandom), 4'($urandom));
    addPacket(1'b0, 1'b0, 1'b0, 1, 4'h3, 4'h0);   // R7 header only, 3 dwords
    addPacket(1'b1, 1'b0, 1'b1, 7, 4'hF, 4'hF);   // R7 header only, 4 dwords
    addPacket(1'b0, 1'b1, 1'b1, 1024, 4'hE, 4'h7); // R1 length field zero
    addPacket(1'b1, 1'b1, 1'b0, 1024, 4'h1, 4'h8);
    for (int p = 0; p < 250; p++)
      addPacket(1'($urandom), ($urandom % 10) != 0, 1'($urandom),
                1 + int'($urandom % 12), 4'($urandom), 4'($urandom));

    cyc = 0; idx = 0; pend = 0;
    while (idx < beatQ.size() || expQ.size() != 0) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog expired R8 actual=%0d expected=%0d", expQ.size(), 0);
        break;
      end
      if (!pend) begin
        if (idx < beatQ.size() && ($urandom % 4) != 0) begin
          inValid = 1'b1; inData = beatQ[idx].d;
          inSop = beatQ[idx].sop; inEop = beatQ[idx].eop;
          pend = 1;
        end else begin
          inValid = 1'b0; inSop = 1'b0; inEop = 1'b0; inData = '0;
        end
      end
      outReady = ($urandom % 3) != 0;
      #1;
      if (!outReady) chk("R8 inReady gated by outReady", 64'(inReady), 64'd0);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          fails++; vectors++;
          $display("FAIL R2 extra output beat actual=%h expected=none", outData);
        end else begin
          e = expQ.pop_front();
          chk("R2/R3 data", outData, e.d);
          chk("R4/R5 byte enables", 64'(outBe), 64'(e.be));
          chk("R6 sop", 64'(outSop), 64'(e.sop));
          chk("R6 eop", 64'(outEop), 64'(e.eop));
          if (e.sop) begin
            chk("R1 length", 64'(hdrLen), 64'(e.len));
            chk("R1 four-dword flag", 64'(hdr4Dw), 64'(e.f4));
            chk("R7 payload flag", 64'(hdrHasData), 64'(e.hd));
            chk("R1 first enables", 64'(hdrFirstBe), 64'(e.fb));
            chk("R1 last enables", 64'(hdrLastBe), 64'(e.lb));
          end
        end
      end
      if (inValid && inReady) begin
        idx++;
        pend = 0;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    #1;
    chk("R2 no beats left over", 64'(expQ.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule